// File: doc/BRIEF.md
# Row-Activate Timing Window Tracker

This block keeps the activate timing for one rank of a DRAM device. Each time a row-activate command is reported, it raises the earliest cycle at which every bank of the rank may take its next activate. The minimum spacing after an activate is longer for banks in the same bank group as the activated bank than for banks in other groups. The block also keeps a short history of the most recent activate cycles so that no more than a set number of activates fall inside a rolling window. When an activate would break that limit, a violation strobe is raised.

A precharge to an open bank sets that bank's earliest re-activate no sooner than the precharge cycle plus the precharge recovery time. The block keeps an open or idle state for every bank and reports how many banks are open. The scheduler supplies the current cycle on `now_cyc`, reads the per-bank earliest-activate times on `nxt_act`, and issues commands elsewhere. Command choice and refresh are handled outside this block. Cycle values are assumed not to wrap within the life of the rank.

The history runs through three states. HS_EMPTY moves to HS_FILL on the first activate, or directly to HS_FULL when the limit is one. HS_FILL moves to HS_FULL on the activate that brings the count of recorded activates to the limit. HS_FULL holds until reset. Each bank has two states. BK_IDLE moves to BK_OPEN on an activate to that bank. BK_OPEN moves to BK_IDLE on an accepted precharge.

Top module: `act_window_tracker`

## Requirements
- R1: After reset, every bank's earliest-activate time is 0, `act_viol` is 0 and `open_cnt` is 0.
- R2: An activate at cycle t raises each bank in the activated bank's group to at least t+T_RRD_L, and every other bank to at least t+T_RRD. The new values appear on `nxt_act` one clock after the strobe. Bank b occupies `nxt_act[b*TW +: TW]`.
- R3: An earliest-activate time is only raised to the maximum of its current value and a new bound. It is never lowered.
- R4: A bank's group is its binary index in `act_bank`/`pre_bank` modulo NGRP. NBANK must be a multiple of NGRP.
- R5: When an activate makes the history hold N_ACT entries, every bank is raised to at least the oldest of the last N_ACT activate cycles (the current activate included) plus T_XAW.
- R6: An activate at t raises `act_viol` for one cycle, one clock later, when N_ACT activates were already recorded and the oldest of them lies less than T_XAW cycles before t. It never fires before N_ACT activates have been seen since reset, although the history resets to all-zero cycle values.
- R7: A precharge at t to an open bank raises only that bank to at least t+T_RP and returns the bank to the idle state.
- R8: A precharge to an idle bank is ignored. No time changes and `open_cnt` is unchanged.
- R9: `open_cnt` goes up by one on an activate to an idle bank and down by one on an accepted precharge. An activate to an open bank leaves it unchanged.
- R10: When an activate and a precharge name the same bank in the same cycle, the precharge is ignored.
- R11: With N_ACT set to 0 the window is disabled. Only the group spacing and precharge bounds apply, and `act_viol` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| now_cyc | input | TW | Current cycle count |
| act_en | input | 1 | Activate strobe |
| act_bank | input | $clog2(NBANK) | Bank index of the activate |
| pre_en | input | 1 | Precharge strobe |
| pre_bank | input | $clog2(NBANK) | Bank index of the precharge |
| nxt_act | output | NBANK*TW | Earliest activate cycle for each bank |
| act_viol | output | 1 | Window limit broken by the previous activate |
| open_cnt | output | $clog2(NBANK+1) | Number of open banks |

## Verification
Activates go to banks in the same group and in different groups, so the long and short spacing can be told apart. Back-to-back pairs are issued where the newer bound is below the held one, which shows that times are held at their maximum and not overwritten. Four quick activates straight after reset show that the zero-valued history causes no false violation. A fifth quick activate, and then a late one, separate a real violation from a window that has already expired. A second instance with the window disabled receives the same activates and must show only the spacing bounds. Precharges are issued to open banks, to idle banks, and to the same bank as a simultaneous activate, which separates the accepted case from the two ignored ones.

// File: rtl/act_win_pkg.sv
package act_win_pkg;

    typedef enum logic [1:0] {
        HS_EMPTY = 2'd0,
        HS_FILL  = 2'd1,
        HS_FULL  = 2'd2
    } hist_st_e;

    typedef enum logic {
        BK_IDLE = 1'b0,
        BK_OPEN = 1'b1
    } bank_st_e;

endpackage

// File: rtl/act_win_hist.sv
module act_win_hist
    import act_win_pkg::*;
#(
    parameter int TW    = 32,
    parameter int N_ACT = 4,
    parameter int T_XAW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_en,
    input  logic [TW-1:0] now,
    output logic          win_hit,
    output logic [TW-1:0] win_base,
    output logic          viol_q
);

    localparam logic [TW-1:0] XAW_T = TW'(T_XAW);

    generate
        if (N_ACT == 0) begin : g_off
            assign win_hit  = 1'b0;
            assign win_base = '0;
            assign viol_q   = 1'b0;
        end else begin : g_on
            localparam int CW = $clog2(N_ACT + 1);
            localparam logic [CW-1:0] LAST_FILL = CW'(N_ACT - 1);

            logic [TW-1:0] hist_q [N_ACT];
            logic [CW-1:0] fill_q;
            hist_st_e      st_q, st_d;
            logic [TW-1:0] oldest_pre;
            logic [TW-1:0] oldest_post;
            logic          viol_d;

            assign oldest_pre = hist_q[N_ACT-1];

            if (N_ACT == 1) begin : g_one
                assign oldest_post = now;
            end else begin : g_many
                assign oldest_post = hist_q[N_ACT-2];
            end

            // state register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st_q <= HS_EMPTY;
                end else begin
                    st_q <= st_d;
                end
            end

            // next state
            always_comb begin
                st_d = st_q;
                unique case (st_q)
                    HS_EMPTY: if (act_en) st_d = (N_ACT == 1) ? HS_FULL : HS_FILL;
                    HS_FILL:  if (act_en && fill_q == LAST_FILL) st_d = HS_FULL;
                    HS_FULL:  st_d = HS_FULL;
                    default:  st_d = HS_EMPTY;
                endcase
            end

            // outputs toward the bank timers
            always_comb begin
                win_hit  = act_en && ((st_q == HS_FULL) || (fill_q == LAST_FILL));
                win_base = oldest_post + XAW_T;
                viol_d   = act_en && (st_q == HS_FULL) && ((now - oldest_pre) < XAW_T);
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    fill_q <= '0;
                    viol_q <= 1'b0;
                    for (int k = 0; k < N_ACT; k++) hist_q[k] <= '0;
                end else begin
                    viol_q <= viol_d;
                    if (act_en) begin
                        hist_q[0] <= now;
                        for (int k = 1; k < N_ACT; k++) hist_q[k] <= hist_q[k-1];
                        if (st_q != HS_FULL) fill_q <= fill_q + 1'b1;
                    end
                end
            end

            // R6
            viol_needs_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
                viol_q |-> ($past(st_q) == HS_FULL));

            // R6
            viol_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (!act_en) |=> !viol_q);
        end
    endgenerate

endmodule

// File: rtl/act_win_bank.sv
module act_win_bank
    import act_win_pkg::*;
#(
    parameter int TW      = 32,
    parameter int T_RRD_L = 8,
    parameter int T_RRD   = 4,
    parameter int T_RP    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] now,
    input  logic          act_any,
    input  logic          act_peer,
    input  logic          act_hit,
    input  logic          pre_hit,
    input  logic          win_hit,
    input  logic [TW-1:0] win_base,
    output logic [TW-1:0] nxt_q,
    output logic          open_q
);

    localparam logic [TW-1:0] RRDL_T = TW'(T_RRD_L);
    localparam logic [TW-1:0] RRD_T  = TW'(T_RRD);
    localparam logic [TW-1:0] RP_T   = TW'(T_RP);

    bank_st_e      st_q, st_d;
    logic          pre_ok;
    logic [TW-1:0] cand_a, cand_w, cand_p;
    logic [TW-1:0] m1, m2, nxt_d;

    assign pre_ok = pre_hit && (st_q == BK_OPEN) && !act_hit;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= BK_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_IDLE: if (act_hit) st_d = BK_OPEN;
            BK_OPEN: if (pre_ok) st_d = BK_IDLE;
            default: st_d = BK_IDLE;
        endcase
    end

    // bound selection, monotonic raise
    always_comb begin
        cand_a = act_any ? (now + (act_peer ? RRDL_T : RRD_T)) : '0;
        cand_w = win_hit ? win_base : '0;
        cand_p = pre_ok ? (now + RP_T) : '0;
        m1     = (cand_a > nxt_q) ? cand_a : nxt_q;
        m2     = (cand_w > m1) ? cand_w : m1;
        nxt_d  = (cand_p > m2) ? cand_p : m2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q <= '0;
        end else begin
            nxt_q <= nxt_d;
        end
    end

    assign open_q = (st_q == BK_OPEN);

    // R3
    never_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (nxt_q >= $past(nxt_q)));

    // R2
    peer_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_any && act_peer) |=> (nxt_q >= $past(now) + RRDL_T));

    // R2
    other_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
        act_any |=> (nxt_q >= $past(now) + RRD_T));

    // R7
    pre_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && !act_hit && open_q) |=> (nxt_q >= $past(now) + RP_T) && !open_q);

    // R8
    pre_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_hit && !act_any && !win_hit && !open_q) |=> $stable(nxt_q));

endmodule

// File: rtl/act_window_tracker.sv
module act_window_tracker
    import act_win_pkg::*;
#(
    parameter int NBANK   = 8,
    parameter int NGRP    = 4,
    parameter int TW      = 32,
    parameter int T_RRD_L = 8,
    parameter int T_RRD   = 4,
    parameter int T_XAW   = 20,
    parameter int N_ACT   = 4,
    parameter int T_RP    = 5,
    localparam int BW     = (NBANK > 1) ? $clog2(NBANK) : 1,
    localparam int CNTW   = $clog2(NBANK + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [TW-1:0]       now_cyc,
    input  logic                act_en,
    input  logic [BW-1:0]       act_bank,
    input  logic                pre_en,
    input  logic [BW-1:0]       pre_bank,
    output logic [NBANK*TW-1:0] nxt_act,
    output logic                act_viol,
    output logic [CNTW-1:0]     open_cnt
);

    logic          win_hit;
    logic [TW-1:0] win_base;
    logic [NBANK-1:0] open_vec;
    int            act_grp_i;

    assign act_grp_i = int'(act_bank) % NGRP;

    act_win_hist #(
        .TW    (TW),
        .N_ACT (N_ACT),
        .T_XAW (T_XAW)
    ) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_en   (act_en),
        .now      (now_cyc),
        .win_hit  (win_hit),
        .win_base (win_base),
        .viol_q   (act_viol)
    );

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            localparam int GRP_B = b % NGRP;
            logic bk_peer, bk_act, bk_pre;

            assign bk_peer = act_en && (act_grp_i == GRP_B);
            assign bk_act  = act_en && (act_bank == BW'(b));
            assign bk_pre  = pre_en && (pre_bank == BW'(b));

            act_win_bank #(
                .TW      (TW),
                .T_RRD_L (T_RRD_L),
                .T_RRD   (T_RRD),
                .T_RP    (T_RP)
            ) u_bank (
                .clk      (clk),
                .rst_n    (rst_n),
                .now      (now_cyc),
                .act_any  (act_en),
                .act_peer (bk_peer),
                .act_hit  (bk_act),
                .pre_hit  (bk_pre),
                .win_hit  (win_hit),
                .win_base (win_base),
                .nxt_q    (nxt_act[b*TW +: TW]),
                .open_q   (open_vec[b])
            );
        end
    endgenerate

    assign open_cnt = CNTW'($countones(open_vec));

    // R9
    cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_en && !act_en && open_vec[pre_bank]) |=> (open_cnt == $past(open_cnt) - 1'b1));

    // R9
    cnt_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && !pre_en && !open_vec[act_bank]) |=> (open_cnt == $past(open_cnt) + 1'b1));

    // R10
    same_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_en && pre_en && (act_bank == pre_bank)) |=> open_vec[$past(act_bank)]);

endmodule

// File: tb/act_window_tracker_tb.sv
module act_window_tracker_tb;

    localparam int NB = 8, NG = 4, TW = 32;
    localparam int RRDL = 8, RRD = 4, XAW = 20, NA = 4, RP = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [TW-1:0] cyc = '0;
    logic act_en = 1'b0, pre_en = 1'b0;
    logic [2:0] act_bank = '0, pre_bank = '0;
    logic [NB*TW-1:0] nxt_w, nxt_n;
    logic viol_w, viol_n;
    logic [3:0] cnt_w, cnt_n;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    act_window_tracker u_dut (
        .clk(clk), .rst_n(rst_n), .now_cyc(cyc), .act_en(act_en), .act_bank(act_bank),
        .pre_en(pre_en), .pre_bank(pre_bank), .nxt_act(nxt_w), .act_viol(viol_w), .open_cnt(cnt_w));

    act_window_tracker #(.N_ACT(0)) u_nowin (
        .clk(clk), .rst_n(rst_n), .now_cyc(cyc), .act_en(act_en), .act_bank(act_bank),
        .pre_en(pre_en), .pre_bank(pre_bank), .nxt_act(nxt_n), .act_viol(viol_n), .open_cnt(cnt_n));

    int checks = 0, fails = 0;
    bit done = 0;
    longint exp_w [NB];
    longint exp_n [NB];
    longint hist [NA];
    int fill = 0;
    bit open_m [NB];
    int ocnt = 0;
    bit exp_viol = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic compare_all(input string req);
        for (int i = 0; i < NB; i++) begin
            chk(nxt_w[i*TW +: TW] == TW'(exp_w[i]), req, nxt_w[i*TW +: TW], exp_w[i]);
            chk(nxt_n[i*TW +: TW] == TW'(exp_n[i]), {req, " R11"}, nxt_n[i*TW +: TW], exp_n[i]);
        end
        chk(viol_w == exp_viol, {req, " R6 viol"}, viol_w, exp_viol);
        chk(viol_n == 1'b0, "R11 viol", viol_n, 0);
        chk(cnt_w == 4'(ocnt), {req, " R9 cnt"}, cnt_w, ocnt);
        chk(cnt_n == 4'(ocnt), {req, " R9 cnt"}, cnt_n, ocnt);
    endtask

    function automatic longint mx(input longint a, input longint b);
        return (a > b) ? a : b;
    endfunction

    task automatic step(input bit a, input int ab, input bit p, input int pb, input string req);
        longint t;
        bit pre_ok;
        @(negedge clk);
        act_en = a; act_bank = 3'(ab); pre_en = p; pre_bank = 3'(pb);
        t = longint'(cyc);
        exp_viol = a && (fill == NA) && (t - hist[NA-1] < XAW);
        pre_ok = p && open_m[pb] && !(a && ab == pb);
        if (a) begin
            for (int i = 0; i < NB; i++) begin
                longint v = t + (((i % NG) == (ab % NG)) ? RRDL : RRD);
                exp_w[i] = mx(exp_w[i], v);
                exp_n[i] = mx(exp_n[i], v);
            end
            for (int k = NA - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = t;
            if (fill < NA) fill++;
            if (fill == NA)
                for (int i = 0; i < NB; i++) exp_w[i] = mx(exp_w[i], hist[NA-1] + XAW);
        end
        if (pre_ok) begin
            exp_w[pb] = mx(exp_w[pb], t + RP);
            exp_n[pb] = mx(exp_n[pb], t + RP);
            open_m[pb] = 0;
            ocnt--;
        end
        if (a && !open_m[ab]) begin
            open_m[ab] = 1;
            ocnt++;
        end
        @(negedge clk);
        act_en = 0; pre_en = 0;
        compare_all(req);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        for (int i = 0; i < NB; i++)
            chk(nxt_w[i*TW +: TW] == '0, "R1 next", nxt_w[i*TW +: TW], 0);
        chk(viol_w == 0, "R1 viol", viol_w, 0);
        chk(cnt_w == 0, "R1 cnt", cnt_w, 0);
    endtask

    task automatic t_startup();
        // R6: zero history must not look like a full window
        step(1, 0, 0, 0, "R6 startup");
        step(1, 1, 0, 0, "R6 startup");
        step(1, 2, 0, 0, "R6 startup");
        step(1, 3, 0, 0, "R5 first full");
    endtask

    task automatic t_spacing();
        idle(40);
        step(1, 1, 0, 0, "R2 R4 group1");
        idle(30);
        step(1, 6, 0, 0, "R2 R4 group2");
    endtask

    task automatic t_monotonic();
        idle(30);
        step(1, 0, 0, 0, "R3 first");
        step(1, 1, 0, 0, "R3 held max");
    endtask

    task automatic t_window();
        idle(30);
        step(1, 2, 0, 0, "R5 w1");
        step(1, 3, 0, 0, "R5 w2");
        step(1, 4, 0, 0, "R5 w3");
        step(1, 5, 0, 0, "R5 w4");
        step(1, 7, 0, 0, "R6 fifth");
        chk(exp_viol == 1, "R6 scenario", exp_viol, 1);
        idle(30);
        step(1, 6, 0, 0, "R6 expired");
    endtask

    task automatic t_precharge();
        idle(30);
        step(0, 0, 1, 5, "R7 pre open");
        step(0, 0, 1, 5, "R8 pre idle");
        step(1, 3, 0, 0, "R9 act open");
        idle(25);
        step(1, 3, 1, 3, "R10 same cycle");
        chk(cnt_w == 4'(ocnt), "R10 stays open", cnt_w, ocnt);
        idle(25);
        step(0, 0, 1, 3, "R7 R9 close");
    endtask

    initial begin
        for (int i = 0; i < NB; i++) begin exp_w[i] = 0; exp_n[i] = 0; open_m[i] = 0; end
        for (int k = 0; k < NA; k++) hist[k] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_startup();
        t_spacing();
        t_monotonic();
        t_window();
        t_precharge();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule